// File: doc/BRIEF.md
# Bus Address/Data Match Comparators

This block watches every cycle of a CPU bus with three independent comparators, named A, B and C, and tells a downstream sequencer which of them matched. The inputs for each bus cycle are the address, the 16-bit data word, a read/write flag, a byte/word size flag and a valid strobe. Each comparator is set up through static configuration inputs. These give its reference address, an enable bit, a direction filter and a class bit. The class bit marks a match as tagged (it acts just before the instruction it marks) or forced (it acts at the next instruction boundary).

The comparators are not all alike. Comparator A also checks the data word under a per-bit mask. Comparator B is the only one that can filter on access size. Comparators A and B can also be joined into one address-range check, either inside or outside a window. In that case A supplies the lower bound and B the upper bound, and the result appears on A's output. Every result is registered, so a match shows up as a one-cycle pulse on the clock edge after the bus cycle that caused it.

Top module: `bus_match_cmp`

## Requirements
- R1: While reset is asserted and after its release with no bus activity, `match` and `match_tag` are all zero.
- R2: `match[i]` goes high for exactly the one cycle that follows a clock edge at which `bus_valid` was high, `cmp_en[i]` was set and comparator i's conditions held. Otherwise it is low.
- R3: In single mode, comparator A (bit 0) hits when `bus_addr == a_addr` and `((bus_data ^ a_data) & a_mask) == 0`. A mask bit of 0 removes that data bit from the comparison.
- R4: Comparator B (bit 1) hits on `bus_addr == b_addr` and comparator C (bit 2) hits on `bus_addr == c_addr`. The data word never affects either of them.
- R5: When `dir_filt_en[i]` is 1, comparator i hits only if `bus_rnw` equals `dir_sel[i]` (`bus_rnw` = 1 means read). When `dir_filt_en[i]` is 0, both directions can hit.
- R6: When `b_size_en` is 1, comparator B hits only if `bus_byte` equals `b_size_sel` (1 = byte access, 0 = word access).
- R7: With `range_mode` = 2'b01 (inside), bit 0 hits when `a_addr <= bus_addr <= b_addr`. Data is not compared, and A's enable and direction filter apply. Bit 1 stays 0.
- R8: With `range_mode` = 2'b10 (outside), bit 0 hits when `bus_addr < a_addr` or `bus_addr > b_addr`, and bit 1 stays 0. The values 2'b00 and 2'b11 both select single mode.
- R9: `match_tag[i]` equals `tag_sel[i]` (1 = tagged, 0 = forced) in the cycle where `match[i]` is 1, and is 0 whenever `match[i]` is 0.
- R10: Comparator C behaves the same in every `range_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data word |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| cmp_en | input | 3 | Per-comparator enable (bit 0 = A, 1 = B, 2 = C) |
| a_addr | input | AW | Comparator A address / range lower bound |
| a_data | input | DW | Comparator A data reference |
| a_mask | input | DW | Comparator A data mask, 1 = bit compared |
| b_addr | input | AW | Comparator B address / range upper bound |
| c_addr | input | AW | Comparator C address |
| dir_filt_en | input | 3 | Per-comparator direction filter enable |
| dir_sel | input | 3 | Direction to accept when filtered, 1 = read |
| b_size_en | input | 1 | Comparator B size filter enable |
| b_size_sel | input | 1 | Size to accept, 1 = byte |
| range_mode | input | 2 | 00/11 single, 01 inside, 10 outside |
| tag_sel | input | 3 | Per-comparator class, 1 = tagged, 0 = forced |
| match | output | 3 | Registered match pulses |
| match_tag | output | 3 | Class of each active match |

## Verification
The bench targets the range boundaries. It places addresses exactly on the lower and upper bounds and one step beyond each. A design that used strict comparisons would lose the edge addresses in inside mode, and one that swapped them would report edge addresses in outside mode. The bench also checks that B goes silent in range mode even when the address equals B's reference. A design that left B's own equality check running would pulse bit 1 there. Other checks cover a masked-out data bit that differs from the reference, a data word that should not matter to B, the wrong direction or size on a filtered comparator, and a bus cycle without the valid strobe. In each case a careless design would produce a stray pulse. The tag checks catch a design that reports a class bit without a match.

// File: rtl/bus_match_cmp.sv
module bus_match_cmp #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_rnw,
  input  logic          bus_byte,
  input  logic [2:0]    cmp_en,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_data,
  input  logic [DW-1:0] a_mask,
  input  logic [AW-1:0] b_addr,
  input  logic [AW-1:0] c_addr,
  input  logic [2:0]    dir_filt_en,
  input  logic [2:0]    dir_sel,
  input  logic          b_size_en,
  input  logic          b_size_sel,
  input  logic [1:0]    range_mode,
  input  logic [2:0]    tag_sel,
  output logic [2:0]    match,
  output logic [2:0]    match_tag
);

  localparam logic [1:0] RM_INSIDE  = 2'b01;
  localparam logic [1:0] RM_OUTSIDE = 2'b10;

  logic [2:0] dir_ok;
  logic [2:0] hit;
  logic       rng_on, above_min, below_max, rng_hit, a_single, b_size_ok;

  assign dir_ok    = ~dir_filt_en | ~(dir_sel ^ {3{bus_rnw}});
  assign rng_on    = (range_mode == RM_INSIDE) || (range_mode == RM_OUTSIDE);
  assign above_min = bus_addr >= a_addr;
  assign below_max = bus_addr <= b_addr;
  assign rng_hit   = (range_mode == RM_INSIDE) ? (above_min & below_max)
                                               : (~above_min | ~below_max);
  assign a_single  = (bus_addr == a_addr) && (((bus_data ^ a_data) & a_mask) == '0);
  assign b_size_ok = ~b_size_en | (bus_byte == b_size_sel);

  assign hit[0] = cmp_en[0] & dir_ok[0] & (rng_on ? rng_hit : a_single);
  assign hit[1] = cmp_en[1] & dir_ok[1] & ~rng_on & b_size_ok & (bus_addr == b_addr);
  assign hit[2] = cmp_en[2] & dir_ok[2] & (bus_addr == c_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match     <= '0;
      match_tag <= '0;
    end else if (bus_valid) begin
      match     <= hit;
      match_tag <= hit & tag_sel;
    end else begin
      match     <= '0;
      match_tag <= '0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (match == 3'b000)); // R2

  AST_DISABLED_C_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en[2] |=> !match[2]); // R2

  AST_DIR_FILTER_C: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_filt_en[2] && (bus_rnw != dir_sel[2])) |=> !match[2]); // R5

  AST_SIZE_FILTER_B: assert property (@(posedge clk) disable iff (!rst_n)
    (b_size_en && (bus_byte != b_size_sel)) |=> !match[1]); // R6

  AST_RANGE_B_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (range_mode == RM_INSIDE || range_mode == RM_OUTSIDE) |=> !match[1]); // R7

  AST_TAG_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_tag & ~match) == 3'b000)); // R9

endmodule

// File: tb/sim_bus_match_cmp.sv
module sim_bus_match_cmp;
  localparam int CLK_PER = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_rnw = 0, bus_byte = 0;
  logic [15:0] bus_addr = 0, bus_data = 0;
  logic [2:0]  cmp_en = 0, dir_filt_en = 0, dir_sel = 0, tag_sel = 0;
  logic [15:0] a_addr = 0, a_data = 0, a_mask = 0, b_addr = 0, c_addr = 0;
  logic        b_size_en = 0, b_size_sel = 0;
  logic [1:0]  range_mode = 0;
  logic [2:0]  match, match_tag;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  bus_match_cmp u0 (.*);

  task automatic chk(input logic [2:0] em, input logic [2:0] et, input string req);
    total++;
    if (match !== em || match_tag !== et) begin
      bad++;
      $display("FAIL %s: match=%b tag=%b expected match=%b tag=%b", req, match, match_tag, em, et);
    end
  endtask

  task automatic cyc(input logic [15:0] ad, input logic [15:0] dt, input logic rnw, input logic byt);
    @(negedge clk);
    bus_valid = 1; bus_addr = ad; bus_data = dt; bus_rnw = rnw; bus_byte = byt;
    @(posedge clk); #1;
    bus_valid = 0;
  endtask

  task automatic t_reset;
    #1 chk(3'b000, 3'b000, "R1 during reset");
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1 chk(3'b000, 3'b000, "R1 after release");
  endtask

  task automatic t_single_a;
    cmp_en = 3'b111; a_addr = 16'h1234; a_data = 16'hABCD; a_mask = 16'hFFFF;
    b_addr = 16'h2000; c_addr = 16'h3000;
    cyc(16'h1234, 16'hABCD, 1, 0); chk(3'b001, 3'b000, "R3 exact hit");
    cyc(16'h1234, 16'hABCC, 1, 0); chk(3'b000, 3'b000, "R3 data miss");
    a_mask = 16'hFF00;
    cyc(16'h1234, 16'hAB00, 0, 0); chk(3'b001, 3'b000, "R3 masked bits ignored");
    cyc(16'h1235, 16'hABCD, 0, 0); chk(3'b000, 3'b000, "R3 address miss");
  endtask

  task automatic t_bc_pulse;
    cyc(16'h2000, 16'h5555, 1, 0); chk(3'b010, 3'b000, "R4 B hit any data");
    @(posedge clk); #1 chk(3'b000, 3'b000, "R2 one-cycle pulse");
    cyc(16'h3000, 16'h0000, 0, 1); chk(3'b100, 3'b000, "R4 C hit");
    @(negedge clk); bus_addr = 16'h3000; bus_valid = 0;
    @(posedge clk); #1 chk(3'b000, 3'b000, "R2 no valid no match");
    cmp_en = 3'b011;
    cyc(16'h3000, 16'h0000, 0, 0); chk(3'b000, 3'b000, "R2 disabled comparator");
    cmp_en = 3'b111;
  endtask

  task automatic t_dir;
    dir_filt_en = 3'b100; dir_sel = 3'b100;
    cyc(16'h3000, 0, 0, 0); chk(3'b000, 3'b000, "R5 write rejected");
    cyc(16'h3000, 0, 1, 0); chk(3'b100, 3'b000, "R5 read accepted");
    dir_sel = 3'b000;
    cyc(16'h3000, 0, 0, 0); chk(3'b100, 3'b000, "R5 write accepted");
    dir_filt_en = 0;
  endtask

  task automatic t_size;
    b_size_en = 1; b_size_sel = 1;
    cyc(16'h2000, 0, 1, 0); chk(3'b000, 3'b000, "R6 word rejected");
    cyc(16'h2000, 0, 1, 1); chk(3'b010, 3'b000, "R6 byte accepted");
    b_size_sel = 0;
    cyc(16'h2000, 0, 1, 0); chk(3'b010, 3'b000, "R6 word accepted");
    b_size_en = 0;
  endtask

  task automatic t_inside;
    range_mode = 2'b01; a_addr = 16'h1000; b_addr = 16'h1FFF;
    cyc(16'h1000, 16'hFFFF, 1, 0); chk(3'b001, 3'b000, "R7 lower bound");
    cyc(16'h1FFF, 16'h0000, 1, 0); chk(3'b001, 3'b000, "R7 upper bound, B silent");
    cyc(16'h2000, 0, 1, 0); chk(3'b000, 3'b000, "R7 above window");
    cyc(16'h0FFF, 0, 1, 0); chk(3'b000, 3'b000, "R7 below window");
  endtask

  task automatic t_outside;
    range_mode = 2'b10;
    cyc(16'h0FFF, 0, 1, 0); chk(3'b001, 3'b000, "R8 below min");
    cyc(16'h2000, 0, 1, 0); chk(3'b001, 3'b000, "R8 above max");
    cyc(16'h1000, 0, 1, 0); chk(3'b000, 3'b000, "R8 lower bound excluded");
    cyc(16'h1FFF, 0, 1, 0); chk(3'b000, 3'b000, "R8 upper bound excluded");
    cyc(16'h3000, 0, 1, 0); chk(3'b101, 3'b000, "R10 C in outside mode");
    range_mode = 2'b11; a_addr = 16'h1234; a_data = 16'hABCD; a_mask = 16'hFFFF;
    cyc(16'h1234, 16'hABCD, 1, 0); chk(3'b001, 3'b000, "R8 code 11 is single");
    cyc(16'h1FFF, 0, 1, 0); chk(3'b010, 3'b000, "R8 code 11 B active");
    range_mode = 2'b00;
  endtask

  task automatic t_tag;
    tag_sel = 3'b101;
    cyc(16'h3000, 0, 1, 0); chk(3'b100, 3'b100, "R9 C tagged");
    cyc(16'h1FFF, 0, 1, 0); chk(3'b010, 3'b000, "R9 B forced");
    cyc(16'h1234, 16'hABCD, 1, 0); chk(3'b001, 3'b001, "R9 A tagged");
    cyc(16'h5555, 0, 1, 0); chk(3'b000, 3'b000, "R9 no tag without match");
    range_mode = 2'b01; a_addr = 16'h1000;
    cyc(16'h1800, 0, 1, 0); chk(3'b001, 3'b001, "R9 range match tagged");
  endtask

  initial begin
    t_reset;
    t_single_a;
    t_bc_pulse;
    t_dir;
    t_size;
    t_inside;
    t_outside;
    t_tag;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule